// File: doc/BRIEF.md
# I2C Register Bank Target with Auto-Increment

This block is an I2C target that gives a bus master read and write access to a small bank of 8-bit registers. It runs on a fast system clock and oversamples the SCL and SDA lines. It pulls SDA low through an open-drain enable and never drives it high. The target answers one 7-bit address. The upper four bits of that address are fixed at `1100` and the lower three bits come from strap pins.

After a write-direction address, the first byte a master sends is a command byte. The command byte sets the register pointer and an auto-increment flag. Later data bytes are written starting at that pointer. To read, the master sends the command byte, then a repeated START, then the address with the read bit set. The target returns the selected register, and with auto-increment set it returns the following registers while the master keeps acknowledging.

Register 0 is a read-only view of an 8-bit external input port. The port is sampled when that byte is loaded for transmission. Registers 1 to `NUM_REGS-1` are writable. The highest `ceil(PINS/4)` of them hold 2-bit selector fields, one per output pin, and each field decides whether its pin is pulled low or released.

Top module: `i2c_regbank`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o`=0), every writable register reads 0 and no pin is pulled low.
- R2: The target acknowledges only the address `{1100, strap_i[2:0]}`. On any other address it sends no ACK, writes nothing and ignores the bus until the next START or STOP.
- R3: The first byte after a matched write address is a command byte. Bits [3:0] are the register pointer and bit 4 is the auto-increment flag; bits [7:5] are ignored. A pointer value above `NUM_REGS-1` selects register 0.
- R4: Each data byte of a write is stored at the pointer and acknowledged. With auto-increment set, the pointer then moves to the next register.
- R5: With auto-increment clear, the pointer stays put, so repeated write bytes overwrite one register and repeated read bytes return one register.
- R6: The pointer wraps from register `NUM_REGS-1` to register 0.
- R7: Register 0 is read-only. A byte written to it is acknowledged and discarded.
- R8: A write address, a command byte, a repeated START and then the read address return the selected register MSB first. Each byte the master ACKs is followed by the next register (auto-increment set). A master NACK ends the read, and the target releases SDA.
- R9: A read of register 0 returns the value of `port_i` sampled on the SCL falling edge that ends the acknowledge bit just before the byte. Later changes to the port do not affect a byte already being shifted out.
- R10: Pin p is controlled by register `NUM_REGS - ceil(PINS/4) + p/4`, bits `[2*(p%4)+1 : 2*(p%4)]`. Code 01 sets `pin_low_o[p]`; codes 00, 10 and 11 leave the pin released.
- R11: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP anywhere, even in the middle of a byte, returns the target to idle with SDA released and no partial byte written. The next transaction then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Low three address bits from strap pins |
| port_i | input | 8 | External input port, readable as register 0 |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | 8*(NUM_REGS-1) | Writable registers 1..NUM_REGS-1, register k at bits [8k-1:8k-8] |
| pin_low_o | output | PINS | Per-pin pull-low request decoded from the selector fields |

## Verification
The bench targets the pointer corner cases. A wrap that skipped register 0, or that ran past the last register, would put burst bytes in the wrong place. A pointer that moved with auto-increment clear would spread repeated bytes across several registers. A command pointer above the last register is also tried. A write to the read-only port register and a wrong strap address are tested to catch a target that corrupts state or drives an ACK it does not own. The input port is changed in the middle of a read to show whether register 0 was latched at the acknowledge edge or read live. Two STOPs sent in the middle of a byte check that an abandoned byte is never committed and that the next transaction still works.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

    localparam logic [3:0] ADDR_PREFIX = 4'b1100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic       ai;
        logic [3:0] ptr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.ai  = b[4];
        c.ptr = b[3:0];
        return c;
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_regbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    // R11: START / STOP are SDA edges while SCL is held high
    assign ev_o.start    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
    assign ev_o.stop     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
    assign ev_o.scl_rise = scl_ff[1] & ~scl_q;
    assign ev_o.scl_fall = ~scl_ff[1] & scl_q;
    assign ev_o.sda      = sda_ff[1];

endmodule

// File: rtl/i2c_regbank_file.sv
module i2c_regbank_file
    import i2c_regbank_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int PINS     = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [3:0]                wr_addr,
    input  logic [7:0]                wr_data,
    input  logic [3:0]                rd_addr,
    input  logic [7:0]                port_i,
    output logic [7:0]                rd_data_o,
    output logic [8*(NUM_REGS-1)-1:0] regs_o,
    output logic [PINS-1:0]           pin_low_o
);
    localparam int RW_REGS  = NUM_REGS - 1;
    localparam int SEL_REGS = (PINS + 3) / 4;
    localparam int SEL_BASE = NUM_REGS - SEL_REGS;

    logic [7:0] mem [RW_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RW_REGS; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            // R7: address 0 has no storage, the byte is dropped
            for (int i = 1; i < NUM_REGS; i++)
                if (wr_addr == 4'(i)) mem[i-1] <= wr_data;
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (rd_addr == 4'd0) rd_data_o = port_i;   // R9: live pins, latched by the shifter
        for (int i = 1; i < NUM_REGS; i++)
            if (rd_addr == 4'(i)) rd_data_o = mem[i-1];
    end

    for (genvar g = 0; g < RW_REGS; g++) begin : g_out
        assign regs_o[8*g +: 8] = mem[g];
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign pin_low_o[p] = (mem[SEL_BASE - 1 + p/4][2*(p%4) +: 2] == 2'b01);  // R10
    end

    assert_ro_discard_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 4'd0) |=> $stable(regs_o));

endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
    import i2c_regbank_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int PINS     = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scl_i,
    input  logic                      sda_i,
    input  logic [2:0]                strap_i,
    input  logic [7:0]                port_i,
    output logic                      sda_oe_o,
    output logic [8*(NUM_REGS-1)-1:0] regs_o,
    output logic [PINS-1:0]           pin_low_o
);
    localparam logic [3:0] LAST_PTR = 4'(NUM_REGS - 1);

    bus_ev_t    ev;
    bus_state_e state;
    logic [7:0] sh;
    logic [2:0] cnt;
    logic       full, is_read, nack, ai;
    logic [3:0] ptr, load_addr;
    logic [7:0] rd_data;
    logic       wr_en;
    cmd_t       cmd;
    logic       addr_hit;

    function automatic logic [3:0] next_ptr(input logic [3:0] p);
        return (p >= LAST_PTR) ? 4'd0 : p + 4'd1;   // R6
    endfunction

    i2c_bus_sync i_sync (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev_o (ev)
    );

    assign cmd       = decode_cmd(sh);
    assign addr_hit  = (sh[7:1] == {ADDR_PREFIX, strap_i});
    assign wr_en     = (state == ST_WDATA) && ev.scl_fall && full;
    assign load_addr = (state == ST_RACK && ai) ? next_ptr(ptr) : ptr;

    i2c_regbank_file #(.NUM_REGS(NUM_REGS), .PINS(PINS)) i_file (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (ptr),
        .wr_data  (sh),
        .rd_addr  (load_addr),
        .port_i   (port_i),
        .rd_data_o(rd_data),
        .regs_o   (regs_o),
        .pin_low_o(pin_low_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sh      <= 8'h00;
            cnt     <= 3'd0;
            full    <= 1'b0;
            is_read <= 1'b0;
            nack    <= 1'b0;
            ai      <= 1'b0;
            ptr     <= 4'd0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
            full  <= 1'b0;
        end else if (ev.start) begin
            state <= ST_ADDR;
            cnt   <= 3'd0;
            full  <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (ev.scl_rise) begin
                        sh   <= {sh[6:0], ev.sda};
                        cnt  <= cnt + 3'd1;
                        full <= (cnt == 3'd7);
                    end else if (ev.scl_fall && full) begin
                        full <= 1'b0;
                        if (state == ST_ADDR) begin
                            is_read <= sh[0];
                            state   <= addr_hit ? ST_ADDR_ACK : ST_IDLE;  // R2
                        end else if (state == ST_CMD) begin
                            ai    <= cmd.ai;                                      // R3
                            ptr   <= (cmd.ptr > LAST_PTR) ? 4'd0 : cmd.ptr;
                            state <= ST_CMD_ACK;
                        end else begin
                            if (ai) ptr <= next_ptr(ptr);                   // R4, R5
                            state <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: if (ev.scl_fall) begin
                    cnt <= 3'd0;
                    if (is_read) begin
                        sh    <= rd_data;   // R9: port captured here
                        state <= ST_RDATA;
                    end else begin
                        state <= ST_CMD;
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: if (ev.scl_fall) begin
                    cnt   <= 3'd0;
                    state <= ST_WDATA;
                end
                ST_RDATA: if (ev.scl_fall) begin
                    sh  <= {sh[6:0], 1'b0};
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) state <= ST_RACK;
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        nack <= ev.sda;
                    end else if (ev.scl_fall) begin
                        if (!nack) begin                // R8
                            ptr   <= load_addr;
                            sh    <= rd_data;
                            cnt   <= 3'd0;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK) ||
                      (state == ST_WDATA_ACK) || (state == ST_RDATA && !sh[7]);

    assert_stop_release_R11: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe_o);

    assert_nomatch_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && ev.scl_fall && full && !addr_hit) |=> !sda_oe_o);

    assert_ptr_range_R6: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST_PTR);

    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ai) |=> $stable(ptr));

    assert_write_ack_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sda_oe_o);

endmodule

// File: tb/test_i2c_regbank.sv
module test_i2c_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 8;
    localparam int NREG       = 5;
    localparam int NPIN       = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] MY_ADDR = {4'b1100, STRAP};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m_low = 1'b0;
    logic [7:0] port = 8'h00;
    logic sda_oe;
    logic [8*(NREG-1)-1:0] regs;
    logic [NPIN-1:0] pin_low;
    logic sda_line;

    int checks = 0;
    int fails  = 0;
    bit quiet  = 0;
    bit done   = 0;

    int mdl [NREG];
    int mptr = 0;
    bit mai  = 0;
    logic [7:0] txq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = !(sda_m_low || sda_oe);

    i2c_regbank #(.NUM_REGS(NREG), .PINS(NPIN)) i_i2c_regbank (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (STRAP),
        .port_i   (port),
        .sda_oe_o (sda_oe),
        .regs_o   (regs),
        .pin_low_o(pin_low)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int nxt(input int p);
        return (p >= NREG-1) ? 0 : p + 1;
    endfunction

    function automatic logic [NPIN-1:0] decode_pins(input logic [8*(NREG-1)-1:0] r);
        logic [NPIN-1:0] v;
        int base;
        base = NREG - (NPIN + 3) / 4;
        for (int p = 0; p < NPIN; p++)
            v[p] = (r[8*(base - 1 + p/4) + 2*(p%4) +: 2] == 2'b01);
        return v;
    endfunction

    function automatic logic [8*(NREG-1)-1:0] model_vec();
        logic [8*(NREG-1)-1:0] v;
        for (int k = 1; k < NREG; k++) v[8*(k-1) +: 8] = mdl[k][7:0];
        return v;
    endfunction

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R10 pin decode", 32'(pin_low), 32'(decode_pins(regs)));
            if (quiet) chk("R2/R11 sda released", 32'(sda_oe), 32'd0);
        end
    end

    task automatic bus_start();
        sda_m_low = 1'b1; wt(PH);
        scl_m = 1'b0;     wt(PH);
    endtask

    task automatic bus_rstart();
        sda_m_low = 1'b0; wt(PH);
        scl_m = 1'b1;     wt(PH);
        bus_start();
    endtask

    task automatic bus_stop();
        sda_m_low = 1'b1; wt(PH);
        scl_m = 1'b1;     wt(PH);
        sda_m_low = 1'b0; wt(PH);
    endtask

    task automatic send_bit(input logic b);
        sda_m_low = !b; wt(PH);
        scl_m = 1'b1;   wt(PH);
        scl_m = 1'b0;   wt(PH);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m_low = 1'b0; wt(PH);
        scl_m = 1'b1;     wt(PH/2);
        ack = !sda_line;  wt(PH/2);
        scl_m = 1'b0;     wt(PH);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m_low = 1'b0; wt(PH);
            scl_m = 1'b1;     wt(PH/2);
            b[i] = sda_line;  wt(PH/2);
            scl_m = 1'b0;     wt(PH);
        end
        sda_m_low = mack; wt(PH);
        scl_m = 1'b1;     wt(PH);
        scl_m = 1'b0;     wt(PH);
        sda_m_low = 1'b0;
    endtask

    task automatic set_cmd(input logic [7:0] c);
        mai  = c[4];
        mptr = (int'(c[3:0]) > NREG-1) ? 0 : int'(c[3:0]);
    endtask

    // write: address, command byte, then every byte in txq
    task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic exp_ack, input string req);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack); chk({req, " addr ack"}, 32'(ack), 32'(exp_ack));
        send_byte(c, ack);         chk({req, " cmd ack"}, 32'(ack), 32'(exp_ack));
        if (exp_ack) set_cmd(c);
        foreach (txq[k]) begin
            send_byte(txq[k], ack);
            chk({req, " data ack"}, 32'(ack), 32'(exp_ack));
            if (exp_ack) begin
                if (mptr != 0) mdl[mptr] = int'(txq[k]);
                if (mai) mptr = nxt(mptr);
            end
        end
        bus_stop();
        txq.delete();
        wt(4);
        chk({req, " registers"}, 32'(regs), 32'(model_vec()));
    endtask

    task automatic do_read(input logic [7:0] c, input int n, input string req);
        logic ack;
        logic [7:0] b;
        int exp;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack); chk({req, " addr ack"}, 32'(ack), 32'd1);
        send_byte(c, ack);               chk({req, " cmd ack"}, 32'(ack), 32'd1);
        set_cmd(c);
        bus_rstart();
        send_byte({MY_ADDR, 1'b1}, ack); chk({req, " read addr ack"}, 32'(ack), 32'd1);
        for (int k = 0; k < n; k++) begin
            exp = (mptr == 0) ? int'(port) : mdl[mptr];
            recv_byte(k != n-1, b);
            chk({req, " read data"}, 32'(b), 32'(exp));
            if (k != n-1 && mai) mptr = nxt(mptr);
        end
        bus_stop();
        wt(4);
        chk({req, " released after NACK"}, 32'(sda_oe), 32'd0);
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        for (int k = 0; k < NREG; k++) mdl[k] = 0;
        wt(5);
        rst = 1'b0;
        wt(3);
        chk("R1 sda released", 32'(sda_oe), 32'd0);
        chk("R1 registers zero", 32'(regs), 32'd0);
        chk("R1 pins released", 32'(pin_low), 32'd0);

        // R2: wrong strap bits -> no ACK anywhere, nothing written
        quiet = 1;
        txq.push_back(8'hEE);
        do_write({4'b1100, 3'b100}, 8'h11, 1'b0, "R2 mismatch");
        quiet = 0;

        // R4: auto-increment burst from register 1
        txq.push_back(8'h12); txq.push_back(8'h34); txq.push_back(8'h56);
        do_write(MY_ADDR, 8'h11, 1'b1, "R4 burst");

        // R5: pointer fixed when auto-increment is clear
        txq.push_back(8'hAA); txq.push_back(8'hBB);
        do_write(MY_ADDR, 8'h02, 1'b1, "R5 fixed write");

        // R6 + R7: wrap from last register through read-only 0 to 1
        txq.push_back(8'h66); txq.push_back(8'h77); txq.push_back(8'h88);
        do_write(MY_ADDR, 8'h14, 1'b1, "R6 R7 wrap");

        // R3: upper command bits ignored, pointer 15 selects register 0
        txq.push_back(8'h99); txq.push_back(8'h42);
        do_write(MY_ADDR, 8'hFF, 1'b1, "R3 command decode");

        // R10: selector registers 3 and 4
        txq.push_back(8'h61); txq.push_back(8'h45);
        do_write(MY_ADDR, 8'h13, 1'b1, "R10 selectors");
        chk("R10 pin_low", 32'(pin_low), 32'h000000B9);

        // R8: combined transfer with auto-increment
        do_read(8'h11, 3, "R8 burst read");
        // R5: repeated reads of one register
        do_read(8'h02, 2, "R5 fixed read");
        // R6: read wraps to the input port then register 1
        port = 8'h5A;
        do_read(8'h14, 3, "R6 wrap read");

        // R9: port snapshot at the acknowledge falling edge
        port = 8'h3C;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h00, ack);
        bus_rstart();
        send_byte({MY_ADDR, 1'b1}, ack);
        port = 8'h81;
        recv_byte(1'b1, b);
        chk("R9 first byte latched", 32'(b), 32'h3C);
        recv_byte(1'b0, b);
        chk("R9 second byte resampled", 32'(b), 32'h81);
        bus_stop();

        // R11: STOP in the middle of an address byte
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(MY_ADDR[6-i]);
        bus_stop();
        quiet = 1; wt(20); quiet = 0;
        // R11: STOP in the middle of a data byte, nothing committed
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h01, ack);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_stop();
        wt(4);
        chk("R11 partial byte dropped", 32'(regs), 32'(model_vec()));
        // R11: bus works again afterwards
        txq.push_back(8'h5A);
        do_write(MY_ADDR, 8'h02, 1'b1, "R11 recovery");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule